// File: doc/BRIEF.md
# Dual-Mode Cartridge Address Decoder

This block sits between a host bus and the memories of a cartridge that carries a coprocessor. It takes a 24-bit host address and picks which of four regions should answer. The regions are program ROM, battery-backed RAM, the coprocessor's on-chip data RAM, and the control I/O space. For the chosen region it also produces a linear offset. A mode input selects one of two memory-map layouts. In one layout the ROM and RAM offsets are packed by squeezing out unused bank bits. In the other layout the address passes almost unchanged.

While the coprocessor owns the bus, the host still reads the interrupt and reset vector area. Those reads are steered into the control I/O space so that the vectors come from registers. Every other host read of ROM in that state gets the open-bus value that came in with the cycle. ROM is never written. The decoder is purely combinational. The memories, the register file and any mirroring to the real memory size are outside it. The selected memory's read byte comes back on `mem_rdata`, and the block forwards the right byte to the host.

Top module: `cart_addr_decoder`

## Requirements
- R1: ROM is selected when bank is 00-3F or 80-BF with address[15]=1, or when bank is C0-FF at any in-bank address, in both modes. The region index for ROM is bit 0 of `rd_sel`/`wr_sel`.
- R2: ROM offset. In mode 0 it is {address[21:16], address[14:0]}, 21 bits, zero-extended. In mode 1 it is address[21:0].
- R3: In mode 0, RAM (bit 1) is selected for banks 70-77 at 0000-7FFF. Its offset is (bank & 7)·8000h + address[14:0].
- R4: In mode 1, RAM (bit 1) is selected for banks 30-3F and B0-BF at 6000-7FFF. Its offset is address[19:16]·2000h + address[12:0].
- R5: Data RAM (bit 2) is selected at 6000-6BFF and 7000-7BFF when address[22]=0, with offset address[11:0]. In mode 1, banks with address[21:20]=11 are excluded.
- R6: I/O (bit 3) is selected at 6C00-6FFF and 7C00-7FFF when address[22]=0, with offset address[9:0]. Mode 1 applies the same bank exclusion as R5.
- R7: When several regions match, the order of preference is ROM, RAM, data RAM, I/O. At most one select bit is ever high.
- R8: An address that matches no region gives no strobes, offset 0 and read data 00h.
- R9: With `cop_busy`=1, a host ROM read is redirected to I/O (bit 3) with offset 340h + address[5:0] when its ROM offset with bits [5:0] cleared equals 7FC0h (mode 0) or 00FFC0h (mode 1).
- R10: With `cop_busy`=1, any other ROM read raises no strobe and returns `open_bus` on `host_rdata`.
- R11: A ROM write never raises a write strobe, whether or not the coprocessor is busy.
- R12: The read and write strobes follow `rd_req` and `wr_req`. `host_rdata` equals `mem_rdata` while a read strobe is high, and is 00h when `rd_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode | input | 1 | Memory-map layout select (0 or 1) |
| addr | input | 24 | Host bus address, bank in [23:16] |
| rd_req | input | 1 | Host read cycle |
| wr_req | input | 1 | Host write cycle |
| cop_busy | input | 1 | Coprocessor owns the bus while the host accesses |
| open_bus | input | 8 | Byte left on the data bus by the previous cycle |
| mem_rdata | input | 8 | Read byte from the selected memory |
| rd_sel | output | 4 | One-hot read strobe: ROM, RAM, data RAM, I/O |
| wr_sel | output | 4 | One-hot write strobe, same order |
| offset | output | 22 | Linear offset into the chosen region |
| host_rdata | output | 8 | Byte returned to the host |

## Verification
The bench aims at the region edges: 7FFF/8000 for ROM, 6BFF/6C00 and 7BFF/7C00 between data RAM and I/O, and the hole at 6000-7FFF in banks 30-3F under mode 1. A decoder with a wrong mask there would route bytes to the wrong memory or let two strobes rise at once. It checks that mode 0 drops address bit 15 and shifts the bank bits down. A non-compressing decoder would hand out offsets with a gap that overruns a 2 MiB ROM. It also covers the vector window at each end and just outside it under `cop_busy`. Getting that wrong either lets the host fetch stale ROM vectors or lets it see registers in place of the open-bus value. Finally, it writes to ROM and reads unmapped space, where a faulty design would raise a strobe or return a stale byte.

// File: rtl/cart_dec_pkg.sv
package cart_dec_pkg;
  localparam int ADDR_W   = 24;
  localparam int OFS_W    = 22;
  localparam int DATA_W   = 8;
  localparam int N_REGION = 4;

  localparam int RG_ROM  = 0;
  localparam int RG_RAM  = 1;
  localparam int RG_DRAM = 2;
  localparam int RG_IO   = 3;

  localparam logic [9:0] VEC_IO_BASE = 10'h340;

  // mode 0 ROM: bank bits [21:16] slide down over the dropped address bit 15
  function automatic logic [OFS_W-1:0] rom_ofs_compact(input logic [ADDR_W-1:0] a);
    return {1'b0, a[21:16], a[14:0]};
  endfunction

  function automatic logic [OFS_W-1:0] rom_ofs_flat(input logic [ADDR_W-1:0] a);
    return a[OFS_W-1:0];
  endfunction

  function automatic logic [OFS_W-1:0] ram_ofs_m0(input logic [ADDR_W-1:0] a);
    return {4'd0, a[18:16], a[14:0]};
  endfunction

  function automatic logic [OFS_W-1:0] ram_ofs_m1(input logic [ADDR_W-1:0] a);
    return {5'd0, a[19:16], a[12:0]};
  endfunction
endpackage

// File: rtl/cart_rom_map.sv
module cart_rom_map
  import cart_dec_pkg::*;
(
  input  logic              mode,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [OFS_W-1:0]  ofs,
  output logic              vec_hit
);
  localparam logic [OFS_W-1:0] VEC_M0 = 22'h007FC0;
  localparam logic [OFS_W-1:0] VEC_M1 = 22'h00FFC0;

  logic low_half_rom;
  logic high_banks;
  logic [OFS_W-1:0] vec_key;

  assign low_half_rom = !addr[22] && addr[15];
  assign high_banks   = addr[23] && addr[22];
  assign hit          = low_half_rom || high_banks;
  assign ofs          = mode ? rom_ofs_flat(addr) : rom_ofs_compact(addr);
  assign vec_key      = {ofs[OFS_W-1:6], 6'd0};
  assign vec_hit      = hit && (vec_key == (mode ? VEC_M1 : VEC_M0));

  always_comb begin
    if (hit && !mode) begin
      AST_ROM_M0_NARROW: assert (ofs[OFS_W-1] == 1'b0) else $error("mode 0 ROM offset above 21 bits"); // R2
    end
  end
endmodule

// File: rtl/cart_ram_map.sv
module cart_ram_map
  import cart_dec_pkg::*;
(
  input  logic              mode,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [OFS_W-1:0]  ofs
);
  logic hit_m0;
  logic hit_m1;

  assign hit_m0 = (addr[23:19] == 5'b01110) && !addr[15];
  assign hit_m1 = (addr[22:20] == 3'b011) && (addr[15:13] == 3'b011);
  assign hit    = mode ? hit_m1 : hit_m0;
  assign ofs    = mode ? ram_ofs_m1(addr) : ram_ofs_m0(addr);

  always_comb begin
    if (hit) begin
      AST_RAM_OFS_WIDTH: assert (ofs[OFS_W-1:18] == '0) else $error("RAM offset too wide"); // R3
    end
  end
endmodule

// File: rtl/cart_chip_map.sv
module cart_chip_map
  import cart_dec_pkg::*;
(
  input  logic              mode,
  input  logic [2:0]        bank_hi,   // address bits [22:20]
  input  logic [15:0]       addr_lo,
  output logic              dram_hit,
  output logic              io_hit,
  output logic [OFS_W-1:0]  dram_ofs,
  output logic [OFS_W-1:0]  io_ofs
);
  logic window;
  logic bank_ok;
  logic upper_quarter;

  assign window        = (addr_lo[15:13] == 3'b011);
  assign bank_ok       = !bank_hi[2] && !(mode && bank_hi[1:0] == 2'b11);
  assign upper_quarter = (addr_lo[11:10] == 2'b11);
  assign dram_hit      = window && bank_ok && !upper_quarter;
  assign io_hit        = window && bank_ok && upper_quarter;
  assign dram_ofs      = {{(OFS_W-12){1'b0}}, addr_lo[11:0]};
  assign io_ofs        = {{(OFS_W-10){1'b0}}, addr_lo[9:0]};

  always_comb begin
    AST_CHIP_EXCLUSIVE: assert (!(dram_hit && io_hit)) else $error("data RAM and I/O both hit"); // R6
    if (dram_hit) begin
      AST_DRAM_BELOW_C00: assert (dram_ofs[11:10] != 2'b11) else $error("data RAM offset in I/O quarter"); // R5
    end
  end
endmodule

// File: rtl/cart_addr_decoder.sv
module cart_addr_decoder
  import cart_dec_pkg::*;
(
  input  logic              mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic              cop_busy,
  input  logic [DATA_W-1:0] open_bus,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [N_REGION-1:0] rd_sel,
  output logic [N_REGION-1:0] wr_sel,
  output logic [OFS_W-1:0]    offset,
  output logic [DATA_W-1:0]   host_rdata
);
  logic rom_hit, ram_hit, dram_hit, io_hit, vec_hit;
  logic [OFS_W-1:0] rom_ofs, ram_ofs, dram_ofs, io_ofs;
  logic [N_REGION-1:0] hit_vec;
  logic [N_REGION-1:0] pick;
  logic [N_REGION-1:0] eff_sel;
  logic redirect;
  logic passthru;

  cart_rom_map u_rom (
    .mode(mode), .addr(addr), .hit(rom_hit), .ofs(rom_ofs), .vec_hit(vec_hit)
  );

  cart_ram_map u_ram (
    .mode(mode), .addr(addr), .hit(ram_hit), .ofs(ram_ofs)
  );

  cart_chip_map u_chip (
    .mode(mode), .bank_hi(addr[22:20]), .addr_lo(addr[15:0]),
    .dram_hit(dram_hit), .io_hit(io_hit), .dram_ofs(dram_ofs), .io_ofs(io_ofs)
  );

  assign hit_vec[RG_ROM]  = rom_hit;
  assign hit_vec[RG_RAM]  = ram_hit;
  assign hit_vec[RG_DRAM] = dram_hit;
  assign hit_vec[RG_IO]   = io_hit;

  // fixed priority: lowest index wins
  always_comb begin
    pick = '0;
    for (int i = N_REGION-1; i >= 0; i--) begin
      if (hit_vec[i]) pick = N_REGION'(1) << i;
    end
  end

  assign redirect = pick[RG_ROM] && cop_busy && rd_req && vec_hit;
  assign passthru = pick[RG_ROM] && cop_busy && rd_req && !vec_hit;

  always_comb begin
    eff_sel = pick;
    if (redirect) eff_sel = N_REGION'(1) << RG_IO;
    else if (passthru) eff_sel = '0;
  end

  always_comb begin
    offset = '0;
    if (redirect)            offset = {{(OFS_W-10){1'b0}}, VEC_IO_BASE | {4'd0, addr[5:0]}};
    else if (pick[RG_ROM])   offset = rom_ofs;
    else if (pick[RG_RAM])   offset = ram_ofs;
    else if (pick[RG_DRAM])  offset = dram_ofs;
    else if (pick[RG_IO])    offset = io_ofs;
  end

  assign rd_sel = rd_req ? eff_sel : '0;
  assign wr_sel = wr_req ? (pick & ~(N_REGION'(1) << RG_ROM)) : '0;

  always_comb begin
    host_rdata = '0;
    if (|rd_sel)       host_rdata = mem_rdata;
    else if (passthru) host_rdata = open_bus;
  end

  always_comb begin
    AST_ONE_REGION: assert ($onehot0(rd_sel) && $onehot0(wr_sel)) else $error("more than one strobe"); // R7
    AST_NO_ROM_WRITE: assert (!wr_sel[RG_ROM]) else $error("ROM write strobe"); // R11
    if (redirect) begin
      AST_VEC_TO_IO: assert (rd_sel[RG_IO] && offset[9:6] == 4'hD) else $error("vector redirect wrong"); // R9
    end
    if (passthru) begin
      AST_OPEN_BUS_QUIET: assert (rd_sel == '0 && host_rdata == open_bus) else $error("open bus pass wrong"); // R10
    end
    if (hit_vec == '0) begin
      AST_UNMAPPED_ZERO: assert (rd_sel == '0 && wr_sel == '0 && host_rdata == '0) else $error("unmapped not quiet"); // R8
    end
  end
endmodule

// File: tb/test_cart_addr_decoder.sv
module test_cart_addr_decoder;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        mode, rd_req, wr_req, cop_busy;
  logic [23:0] addr;
  logic [7:0]  open_bus, mem_rdata;
  logic [3:0]  rd_sel, wr_sel;
  logic [21:0] offset;
  logic [7:0]  host_rdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  cart_addr_decoder i_cart_addr_decoder (
    .mode(mode), .addr(addr), .rd_req(rd_req), .wr_req(wr_req), .cop_busy(cop_busy),
    .open_bus(open_bus), .mem_rdata(mem_rdata),
    .rd_sel(rd_sel), .wr_sel(wr_sel), .offset(offset), .host_rdata(host_rdata)
  );

  // independent model built from bank / in-bank ranges
  task automatic model(input logic m, input logic [23:0] a, input logic rd, input logic wr,
                       input logic busy, input logic [7:0] ob, input logic [7:0] md,
                       output logic [3:0] e_rd, output logic [3:0] e_wr,
                       output logic [21:0] e_ofs, output logic [7:0] e_data);
    int bank = int'(a[23:16]);
    int low  = int'(a[15:0]);
    bit rom, ram, dram, io, in_win, bank_ok, vec;
    int rom_o, ram_o;
    int region;
    rom = ((bank <= 'h3F || (bank >= 'h80 && bank <= 'hBF)) && low >= 'h8000) || bank >= 'hC0;
    rom_o = m ? int'(a) % (1 << 22) : (bank % 64) * 32768 + (low % 32768);
    if (!m) begin
      ram = bank >= 'h70 && bank <= 'h77 && low < 'h8000;
      ram_o = (bank - 'h70) * 32768 + low;
    end else begin
      ram = ((bank >= 'h30 && bank <= 'h3F) || (bank >= 'hB0 && bank <= 'hBF)) && low >= 'h6000 && low < 'h8000;
      ram_o = (bank % 16) * 8192 + (low - 'h6000);
    end
    in_win  = low >= 'h6000 && low < 'h8000;
    bank_ok = (bank % 128) < 64 && !(m && (bank % 64) >= 'h30);
    dram = in_win && bank_ok && ((low % 4096) < 'hC00);
    io   = in_win && bank_ok && ((low % 4096) >= 'hC00);
    vec  = (rom_o / 64) * 64 == (m ? 'hFFC0 : 'h7FC0);
    region = rom ? 0 : ram ? 1 : dram ? 2 : io ? 3 : -1;
    e_rd = 0; e_wr = 0; e_ofs = 0; e_data = 0;
    case (region)
      0: e_ofs = 22'(rom_o);
      1: e_ofs = 22'(ram_o);
      2: e_ofs = 22'(low % 4096);
      3: e_ofs = 22'(low % 1024);
      default: e_ofs = 0;
    endcase
    if (wr && region > 0) e_wr = 4'(1 << region);
    if (rd && region >= 0) begin
      if (region == 0 && busy) begin
        if (vec) begin
          e_rd = 4'b1000; e_ofs = 22'('h340 + (low % 64)); e_data = md;
        end else e_data = ob;
      end else begin
        e_rd = 4'(1 << region); e_data = md;
      end
    end
  endtask

  task automatic probe(input string req, input logic m, input logic [23:0] a,
                       input logic rd, input logic wr, input logic busy);
    logic [3:0] e_rd, e_wr; logic [21:0] e_ofs; logic [7:0] e_d;
    @(negedge clk);
    mode = m; addr = a; rd_req = rd; wr_req = wr; cop_busy = busy;
    open_bus = 8'h5A ^ a[7:0]; mem_rdata = 8'hC3 ^ a[15:8];
    #1;
    model(m, a, rd, wr, busy, open_bus, mem_rdata, e_rd, e_wr, e_ofs, e_d);
    checks++;
    if (rd_sel !== e_rd || wr_sel !== e_wr || offset !== e_ofs || host_rdata !== e_d) begin
      errors++;
      $display("FAIL %s m=%0d a=%h: rd %b/%b wr %b/%b ofs %h/%h data %h/%h (actual/expected)",
               req, m, a, rd_sel, e_rd, wr_sel, e_wr, offset, e_ofs, host_rdata, e_d);
    end
  endtask

  task automatic expect_fixed(input string req, input logic [3:0] x_rd, input logic [21:0] x_ofs,
                              input logic [7:0] x_d);
    checks++;
    if (rd_sel !== x_rd || offset !== x_ofs || host_rdata !== x_d) begin
      errors++;
      $display("FAIL %s: rd %b/%b ofs %h/%h data %h/%h (actual/expected)",
               req, rd_sel, x_rd, offset, x_ofs, host_rdata, x_d);
    end
  endtask

  task automatic t_idle();
    probe("R12 idle", 0, 24'h000000, 0, 0, 0);
    checks++;
    if (rd_sel !== 0 || wr_sel !== 0 || host_rdata !== 0) begin
      errors++;
      $display("FAIL R12 idle: rd %b wr %b data %h expected 0", rd_sel, wr_sel, host_rdata);
    end
  endtask

  task automatic t_rom();
    probe("R1", 0, 24'h008000, 1, 0, 0);
    expect_fixed("R1 R2 m0 00:8000", 4'b0001, 22'h0, 8'hC3 ^ 8'h80);
    probe("R1", 0, 24'h007FFF, 1, 0, 0);
    probe("R2", 0, 24'h3FFFFF, 1, 0, 0);
    expect_fixed("R2 m0 3F:FFFF", 4'b0001, 22'h1FFFFF, 8'hC3 ^ 8'hFF);
    probe("R2", 0, 24'hC12345, 1, 0, 0);
    probe("R2", 1, 24'hC12345, 1, 0, 0);
    expect_fixed("R2 m1 C1:2345", 4'b0001, 22'h012345, 8'hC3 ^ 8'h23);
    probe("R1", 1, 24'h408000, 1, 0, 0);
    probe("R1", 1, 24'hBF8000, 1, 0, 0);
  endtask

  task automatic t_ram();
    probe("R3", 0, 24'h721234, 1, 0, 0);
    expect_fixed("R3 72:1234", 4'b0010, 22'h011234, 8'hC3 ^ 8'h12);
    probe("R3", 0, 24'h777FFF, 0, 1, 0);
    probe("R3", 0, 24'h780000, 1, 0, 0);
    probe("R4", 1, 24'h3A6001, 1, 0, 0);
    expect_fixed("R4 3A:6001", 4'b0010, 22'h014001, 8'hC3 ^ 8'h60);
    probe("R4", 1, 24'hBF7FFF, 0, 1, 0);
    probe("R4", 1, 24'h705000, 1, 0, 0);
  endtask

  task automatic t_chip();
    probe("R5", 0, 24'h006BFF, 1, 0, 0);
    expect_fixed("R5 00:6BFF", 4'b0100, 22'h000BFF, 8'hC3 ^ 8'h6B);
    probe("R6", 0, 24'h006C00, 1, 0, 0);
    expect_fixed("R6 00:6C00", 4'b1000, 22'h000000, 8'hC3 ^ 8'h6C);
    probe("R5", 0, 24'h907001, 0, 1, 0);
    probe("R6", 0, 24'h2F7FFF, 0, 1, 0);
    probe("R5", 0, 24'h356000, 1, 0, 0);
    probe("R5", 1, 24'h2F6000, 1, 0, 0);
    probe("R6", 1, 24'hAF7C00, 1, 0, 0);
    probe("R6", 0, 24'h406C00, 1, 0, 0);
  endtask

  task automatic t_priority();
    probe("R7", 1, 24'h306C00, 1, 0, 0);
    expect_fixed("R7 m1 30:6C00 to RAM", 4'b0010, 22'h000C00, 8'hC3 ^ 8'h6C);
    probe("R7", 1, 24'hB07000, 1, 1, 0);
  endtask

  task automatic t_unmapped();
    probe("R8", 0, 24'h405000, 1, 1, 0);
    expect_fixed("R8 40:5000", 4'b0000, 22'h0, 8'h00);
    probe("R8", 1, 24'h700000, 1, 1, 0);
    probe("R8", 0, 24'h001234, 1, 0, 0);
  endtask

  task automatic t_busy();
    probe("R9", 1, 24'h00FFC0, 1, 0, 1);
    expect_fixed("R9 m1 00:FFC0", 4'b1000, 22'h000340, 8'hC3 ^ 8'hFF);
    probe("R9", 1, 24'h00FFFF, 1, 0, 1);
    expect_fixed("R9 m1 00:FFFF", 4'b1000, 22'h00037F, 8'hC3 ^ 8'hFF);
    probe("R9", 0, 24'h00FFEA, 1, 0, 1);
    probe("R9", 0, 24'hC07FC5, 1, 0, 1);
    probe("R10", 1, 24'h00FFBF, 1, 0, 1);
    expect_fixed("R10 m1 00:FFBF", 4'b0000, 22'h00FFBF, 8'h5A ^ 8'hBF);
    probe("R10", 1, 24'h40FFC0, 1, 0, 1);
    probe("R10", 0, 24'h01FFC0, 1, 0, 1);
    probe("R10", 0, 24'h006C10, 1, 0, 1);
  endtask

  task automatic t_rom_write();
    probe("R11", 0, 24'h00FFC0, 0, 1, 1);
    probe("R11", 1, 24'hD00000, 0, 1, 0);
    checks++;
    if (wr_sel !== 4'b0000) begin
      errors++;
      $display("FAIL R11 ROM write: wr %b expected 0000", wr_sel);
    end
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 600; i++) begin
      logic [23:0] a;
      a = {8'(i * 37 + 5), 16'(i * 1291 + 24576)};
      probe("R12 sweep", i[0], a, i[1], i[2], i[3]);
    end
  endtask

  initial begin
    mode = 0; addr = 0; rd_req = 0; wr_req = 0; cop_busy = 0; open_bus = 0; mem_rdata = 0;
    t_idle();
    t_rom();
    t_ram();
    t_chip();
    t_priority();
    t_unmapped();
    t_busy();
    t_rom_write();
    t_sweep();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule